// File: doc/BRIEF.md
# SPI Register Slave with Deferred Readback

This block is the serial control port of a multi-channel output converter. A host drives 24-bit frames over a four-wire SPI link. Each frame opens with a falling chip select and closes with a rising one. A frame holds a command byte and a 16-bit word. The MSB of the command byte selects read or write, and the other seven bits give the register address. A write takes effect only when chip select rises, so a frame that is cut short or runs long never touches the register file.

A read is split across two frames. The request frame only names the register. The reply leaves on MISO during the next frame, which the host usually fills with all zeros. A user test bit in the control register also appears in a read-only status register, so the host can test the full write-and-read path. A key word written to the reset register restores every register. An active-low device reset pin does the same.

The SPI pins are oversampled in the system clock domain. The register contents are presented as one flat bus. A strobe marks each update of the output value register.

Top module: `spi_regslave`

## Requirements
- R1: A frame is 24 SCLK rising edges while `spi_cs_n` is low, MSB first, with MOSI sampled on the rising SCLK edge. Bit 23 is the read flag (1 = read), bits 22..16 are the register address and bits 15..0 are the data word. A write frame loads the data word into the addressed register.
- R2: A write reaches `regs_o` only after `spi_cs_n` rises. While the frame is still open, `regs_o` keeps its earlier value.
- R3: After a read request, the next frame carries a 24-bit reply on MISO, MSB first, changing on falling SCLK edges. The reply is {0, 7-bit address, 16-bit register value}. The data word of the request is ignored.
- R4: During a frame that does not follow a valid read request, MISO stays 0.
- R5: Bit 0 of register 0x02 is a user bit. It appears at bit 6 of read-only register 0x0B, and every other bit of 0x0B reads 0. Writes to 0x0B change nothing.
- R6: Writing 0x0001 to register 0x01 restores every register to its default. Any other value written to 0x01 changes nothing.
- R7: Holding `dev_rst_n` low restores every register to its default.
- R8: A frame with any number of SCLK rising edges other than 24 is discarded and changes no register.
- R9: An address with no register reads back 0x0000, and writes to it are ignored.
- R10: `data_strobe` is high for exactly one clock cycle each time register 0x05 is written, and at no other time.
- R11: After reset, registers 0x02 to 0x06 are 0x0000 and register 0x07 is 0x8000. `regs_o[16*k +: 16]` holds register 0x02+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| dev_rst_n | input | 1 | Active-low device reset pin, restores register defaults |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select that frames a transfer |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| regs_o | output | 96 | Six 16-bit registers 0x02..0x07, lowest address in the lowest bits |
| data_strobe | output | 1 | One-cycle pulse when register 0x05 is written |

## Verification
The assertions take for granted that SCLK, chip select and MOSI each hold a level long enough for the synchronizer and edge detector to see every transition. They also assume that MOSI is stable around each rising SCLK edge and that chip select does not toggle while SCLK is high. The stimulus keeps to this with an SCLK half-period of eight system clocks. It also leaves several idle cycles after a falling chip select and before a rising one. Device reset pulses are held for several cycles, so the synchronized level is always seen.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int REG_AW  = ADDR_W - 1;
    localparam int NUM_RW  = 6;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [REG_AW-1:0] RW_BASE   = 7'h02;
    localparam logic [REG_AW-1:0] A_SOFTRST = 7'h01;
    localparam logic [REG_AW-1:0] A_STATUS  = 7'h0B;
    localparam logic [REG_AW-1:0] A_OUTVAL  = 7'h05;
    localparam logic [REG_AW-1:0] A_USER    = 7'h02;

    localparam int USER_BIT   = 0;
    localparam int MIRROR_BIT = 6;

    localparam logic [DATA_W-1:0] SOFTRST_KEY = 16'h0001;

    // pin order inside the synchronizer vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_MOSI = 1;
    localparam int PIN_CSN  = 2;
    localparam int PIN_DRST = 3;
    localparam int NUM_PINS = 4;

    typedef struct packed {
        logic              rd;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [DATA_W-1:0] rw_default(input int idx);
        return (idx == 5) ? 16'h8000 : '0;
    endfunction

    function automatic logic rw_hit(input logic [REG_AW-1:0] a, input int idx);
        return a == (RW_BASE + REG_AW'(idx));
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_regslave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic cs_n_i,
    input  logic dev_rst_n_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_n_s,
    output logic cs_rise,
    output logic cs_fall,
    output logic dev_rst_n_s
);
    localparam logic [NUM_PINS-1:0] IDLE_LVL = (NUM_PINS'(1) << PIN_CSN) | (NUM_PINS'(1) << PIN_DRST);

    logic [NUM_PINS-1:0] stg [STAGES];
    logic [NUM_PINS-1:0] pins, last;
    logic                sclk_d, cs_d;

    always_comb begin
        pins           = '0;
        pins[PIN_SCLK] = sclk_i;
        pins[PIN_MOSI] = mosi_i;
        pins[PIN_CSN]  = cs_n_i;
        pins[PIN_DRST] = dev_rst_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= IDLE_LVL;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            stg[0] <= pins;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            sclk_d <= last[PIN_SCLK];
            cs_d   <= last[PIN_CSN];
        end
    end

    assign last        = stg[STAGES-1];
    assign mosi_s      = last[PIN_MOSI];
    assign cs_n_s      = last[PIN_CSN];
    assign dev_rst_n_s = last[PIN_DRST];
    assign sclk_rise   =  last[PIN_SCLK] & ~sclk_d;
    assign sclk_fall   = ~last[PIN_SCLK] &  sclk_d;
    assign cs_rise     =  last[PIN_CSN]  & ~cs_d;
    assign cs_fall     = ~last[PIN_CSN]  &  cs_d;

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_regslave_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   cs_n_s,
    input  logic   cs_rise,
    input  logic   cs_fall,
    input  logic   sclk_rise,
    input  logic   mosi_s,
    output logic   frame_end,
    output logic   frame_ok,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   nbits;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg     <= '0;
            nbits     <= '0;
            frame_end <= 1'b0;
            frame_ok  <= 1'b0;
            frame     <= '0;
        end else begin
            frame_end <= 1'b0;
            frame_ok  <= 1'b0;
            if (cs_fall) begin
                nbits <= '0;
            end else if (!cs_n_s && sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], mosi_s};
                if (nbits != CNT_MAX) nbits <= nbits + 1'b1;
            end
            if (cs_rise) begin
                frame_end <= 1'b1;
                frame_ok  <= (nbits == CNT_GOOD);
                frame     <= frame_t'(shreg);
            end
        end
    end

    p_ok_inside_end_r8: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> frame_end);

    p_end_single_r2: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regslave_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_RW*DATA_W-1:0] regs_o,
    output logic                     data_strobe
);
    localparam int USER_IDX = int'(A_USER - RW_BASE);

    logic [NUM_RW-1:0][DATA_W-1:0] q;
    logic                          soft_hit;
    logic [DATA_W-1:0]             status;

    assign soft_hit = wr_en && (wr_addr == A_SOFTRST) && (wr_data == SOFTRST_KEY);

    always_ff @(posedge clk) begin
        if (rst || clr || soft_hit) begin
            for (int i = 0; i < NUM_RW; i++) q[i] <= rw_default(i);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_RW; i++)
                if (rw_hit(wr_addr, i)) q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) data_strobe <= 1'b0;
        else            data_strobe <= wr_en && (wr_addr == A_OUTVAL);
    end

    always_comb begin
        status             = '0;
        status[MIRROR_BIT] = q[USER_IDX][USER_BIT];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STATUS) rd_data = status;
        for (int i = 0; i < NUM_RW; i++)
            if (rw_hit(rd_addr, i)) rd_data = q[i];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_RW; g++) begin : g_flat
            assign regs_o[g*DATA_W +: DATA_W] = q[g];
        end
    endgenerate

    p_commit_only_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clr) |=> $stable(regs_o));

    p_strobe_cause_r10: assert property (@(posedge clk) disable iff (rst)
        data_strobe |-> $past(wr_en && wr_addr == A_OUTVAL));

    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        data_strobe |=> !data_strobe);

endmodule

// File: rtl/spi_tx.sv
module spi_tx
    import spi_regslave_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               shift,
    input  logic               cs_n_s,
    output logic               miso
);
    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr)  sh <= '0;
        else if (load)   sh <= load_val;
        else if (shift)  sh <= {sh[FRAME_W-2:0], 1'b0};
    end

    assign miso = ~cs_n_s & sh[FRAME_W-1];

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift && !clr) |=> $stable(sh));

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dev_rst_n,
    input  logic                     spi_sclk,
    input  logic                     spi_cs_n,
    input  logic                     spi_mosi,
    output logic                     spi_miso,
    output logic [NUM_RW*DATA_W-1:0] regs_o,
    output logic                     data_strobe
);
    logic sclk_rise, sclk_fall, mosi_s, cs_n_s, cs_rise, cs_fall, dev_rst_n_s;
    logic clr, frame_end, frame_ok, wr_en;
    frame_t             frame;
    logic [DATA_W-1:0]  rd_data;
    logic [FRAME_W-1:0] reply;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(spi_sclk), .mosi_i(spi_mosi), .cs_n_i(spi_cs_n), .dev_rst_n_i(dev_rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s), .cs_n_s(cs_n_s),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .dev_rst_n_s(dev_rst_n_s)
    );

    assign clr = ~dev_rst_n_s;

    spi_frame_rx u_rx (
        .clk(clk), .rst(rst), .clr(clr),
        .cs_n_s(cs_n_s), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .frame_end(frame_end), .frame_ok(frame_ok), .frame(frame)
    );

    assign wr_en = frame_ok & ~frame.rd;

    spi_reg_bank u_bank (
        .clk(clk), .rst(rst), .clr(clr),
        .wr_en(wr_en), .wr_addr(frame.addr), .wr_data(frame.data),
        .rd_addr(frame.addr), .rd_data(rd_data),
        .regs_o(regs_o), .data_strobe(data_strobe)
    );

    assign reply = (frame_ok && frame.rd) ? {1'b0, frame.addr, rd_data} : '0;

    spi_tx u_tx (
        .clk(clk), .rst(rst), .clr(clr),
        .load(frame_end), .load_val(reply),
        .shift(sclk_fall & ~cs_n_s), .cs_n_s(cs_n_s),
        .miso(spi_miso)
    );

endmodule

// File: tb/spi_regslave_bench.sv
module spi_regslave_bench;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dev_rst_n = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [95:0] regs_o;
    logic        data_strobe;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit exp_strobe = 1'b0;
    int strobe_seen = 0;
    int strobe_want = 0;
    bit finished = 1'b0;

    logic [15:0] mdl [0:127];

    always #2 clk = ~clk;

    spi_regslave u_spi_regslave (
        .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .regs_o(regs_o), .data_strobe(data_strobe)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mreset();
        for (int a = 0; a < 128; a++) mdl[a] = 16'h0000;
        mdl[7] = 16'h8000;
    endtask

    function automatic logic [95:0] mflat();
        logic [95:0] v;
        for (int k = 0; k < 6; k++) v[k*16 +: 16] = mdl[k+2];
        return v;
    endfunction

    function automatic logic [15:0] mread(input logic [6:0] a);
        if (a == 7'h0B) return {9'b0, mdl[2][0], 6'b0};
        if (a >= 7'h02 && a <= 7'h07) return mdl[a];
        return 16'h0000;
    endfunction

    task automatic mwrite(input logic [6:0] a, input logic [15:0] d);
        if (a >= 7'h02 && a <= 7'h07) mdl[a] = d;
        else if (a == 7'h01 && d == 16'h0001) mreset();
    endtask

    // continuous comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(regs_o == mflat(), "R1 register state", regs_o, mflat());
            chk(data_strobe == exp_strobe, "R10 strobe", 96'(data_strobe), 96'(exp_strobe));
        end
    end

    always @(posedge clk) if (!rst && data_strobe) strobe_seen++;

    task automatic xfer(input logic [23:0] word, input int nbits, output logic [23:0] got);
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? word[23-i] : 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            if (i < 24) got[23-i] = miso;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        chk(regs_o == mflat(), "R2 open frame", regs_o, mflat());
        cs_n = 1'b1;
        repeat (4) @(posedge clk);
        if (nbits == 24 && !word[23]) begin
            mwrite(word[22:16], word[15:0]);
            if (word[22:16] == 7'h05) begin
                strobe_want++;
                exp_strobe = 1'b1;
                @(posedge clk);
                exp_strobe = 1'b0;
            end
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d, output logic [23:0] got);
        xfer({1'b0, a, d}, 24, got);
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [15:0] junk, input string req);
        logic [23:0] g;
        logic [23:0] e;
        xfer({1'b1, a, junk}, 24, g);
        e = {1'b0, a, mread(a)};
        xfer(24'h0, 24, g);
        chk(g == e, req, 96'(g), 96'(e));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] g;
        mreset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_on = 1'b1;
        // R11 defaults
        chk(regs_o == {16'h8000, 80'h0}, "R11 defaults", regs_o, {16'h8000, 80'h0});

        // R1 writes
        wr(7'h05, 16'h1234, g);
        chk(regs_o[3*16 +: 16] == 16'h1234, "R1 write 0x05", 96'(regs_o[3*16 +: 16]), 96'h1234);
        wr(7'h03, 16'hA5C3, g);
        chk(g == 24'h0, "R4 miso after write", 96'(g), 96'h0);
        chk(regs_o[1*16 +: 16] == 16'hA5C3, "R1 write 0x03", 96'(regs_o[1*16 +: 16]), 96'hA5C3);
        wr(7'h04, 16'h0F00, g);
        chk(g == 24'h0, "R4 miso after write", 96'(g), 96'h0);

        // R3 deferred read, junk data ignored
        rd_chk(7'h05, 16'hFFFF, "R3 read 0x05");
        rd_chk(7'h07, 16'h5A5A, "R3 read 0x07");
        rd_chk(7'h03, 16'h0000, "R3 read 0x03");
        xfer(24'h0, 24, g);
        chk(g == 24'h0, "R4 miso after nop", 96'(g), 96'h0);

        // R5 user bit mirror
        rd_chk(7'h0B, 16'h0000, "R5 status clear");
        wr(7'h02, 16'h0001, g);
        rd_chk(7'h0B, 16'h1234, "R5 status mirror");
        wr(7'h0B, 16'hFFFF, g);
        rd_chk(7'h0B, 16'h0000, "R5 status read-only");
        wr(7'h02, 16'h0000, g);
        rd_chk(7'h0B, 16'h0000, "R5 status cleared");

        // R9 unimplemented address
        wr(7'h20, 16'hBEEF, g);
        rd_chk(7'h20, 16'h0000, "R9 unimplemented read");
        rd_chk(7'h00, 16'h0000, "R9 address zero read");

        // R8 malformed frames
        xfer({1'b0, 7'h05, 16'h0F0F}, 23, g);
        chk(regs_o[3*16 +: 16] == 16'h1234, "R8 short frame", 96'(regs_o[3*16 +: 16]), 96'h1234);
        xfer({1'b0, 7'h05, 16'h0F0F}, 25, g);
        chk(regs_o[3*16 +: 16] == 16'h1234, "R8 long frame", 96'(regs_o[3*16 +: 16]), 96'h1234);

        // R6 soft reset
        wr(7'h07, 16'h0042, g);
        wr(7'h01, 16'h0002, g);
        chk(regs_o[5*16 +: 16] == 16'h0042, "R6 wrong key ignored", 96'(regs_o[5*16 +: 16]), 96'h0042);
        wr(7'h01, 16'h0001, g);
        chk(regs_o == {16'h8000, 80'h0}, "R6 soft reset", regs_o, {16'h8000, 80'h0});

        // R7 device reset pin
        wr(7'h05, 16'hCAFE, g);
        wr(7'h06, 16'h7777, g);
        @(negedge clk) dev_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        mreset();
        repeat (6) @(negedge clk);
        dev_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(regs_o == {16'h8000, 80'h0}, "R7 device reset", regs_o, {16'h8000, 80'h0});
        rd_chk(7'h05, 16'h0000, "R3 read after device reset");

        // R10 pulse count
        chk(strobe_seen == strobe_want, "R10 strobe count", 96'(strobe_seen), 96'(strobe_want));

        cmp_on = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule